// File: doc/BRIEF.md
# Banked Page-Write Front End for a Serial Presence Memory

This block sits between a serial slave byte decoder and a 512-byte presence memory. The memory is split into two banks of 256 bytes, and only one bank is visible at a time. A bank selector chooses the visible bank. It comes up pointing at bank 0 and can be changed by command. Software can lock each 128-byte quarter of the memory against writes. A lock stays set until a dedicated clear command is issued.

The decoder passes in one command per cycle, with an address byte and a data byte. Written bytes are collected in a 16-byte page buffer. A commit command then starts a timed write cycle. During that cycle `busy` is high and every command is refused. In the last busy cycle the staged bytes go into the storage array in a single row write, with one write strobe per byte lane. The storage array is a plain RAM inside the block. Reads return one byte of the visible bank.

Top module: `spd_pw_top`

## Requirements
- R1: After reset, `busy`, `rd_valid` and `mem_we` are low, bank 0 is the visible bank and the page buffer is empty. The storage contents are not cleared by reset.
- R2: An accepted READ (op 7) drives `rd_data` with the byte at {visible bank, `cmd_addr`} and raises `rd_valid` for one cycle. Both appear in the cycle after the command.
- R3: ADDR (op 1) latches the page (bank bits plus `cmd_addr[7:4]`), sets the byte slot to `cmd_addr[3:0]` and empties the buffer. Each DATA (op 2) byte fills the current slot, and the slot then advances modulo 16 within the same page. A later byte overwrites an earlier byte in the same slot.
- R4: A commit writes only the slots filled since the last ADDR. It writes them into the page and bank latched by that ADDR, and leaves every other byte of the array unchanged.
- R5: An accepted COMMIT (op 3) that starts a write holds `busy` high for exactly WR_CYCLES cycles, starting in the cycle after the command. `mem_we` shows the filled-slot mask, with bit i for slot i, in the last busy cycle only. In that cycle `mem_row` = {bank, page}.
- R6: While `busy` is high, every command is ignored. Bank, locks, buffer and address are left untouched, and no read response is produced.
- R7: BANK (op 4) makes bank `cmd_data[0]` the visible bank for subsequent reads and ADDR commands.
- R8: PSET (op 5) locks quarter `cmd_data[1:0]`, where quarter = {bank, address bit 7}. A commit whose page lies in a locked quarter raises neither `busy` nor `mem_we`, leaves the array unchanged and empties the buffer.
- R9: A lock stays set through ADDR, DATA, COMMIT, BANK and READ commands. Only PCLR (op 6) clears it, and PCLR clears all four locks.
- R10: A COMMIT with an empty buffer starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Command code: 0 none, 1 ADDR, 2 DATA, 3 COMMIT, 4 BANK, 5 PSET, 6 PCLR, 7 READ |
| cmd_addr | input | 8 | Byte address within the visible bank |
| cmd_data | input | 8 | Data byte, bank number or quarter index |
| busy | output | 1 | Write cycle in progress; commands are refused |
| mem_we | output | 16 | Per-byte write strobes into the array row |
| mem_row | output | 5 | Array row being written, {bank, page} |
| rd_data | output | 8 | Read data |
| rd_valid | output | 1 | Read data valid |

## Verification
Every page of both banks is filled with a pattern that depends on bank, page and slot, and all 512 bytes are then read back. This separates a wrong bank bit, a wrong page or a swapped byte lane. Runs of 20 bytes and of 3 bytes, each starting mid-page, distinguish correct in-page wraparound from spilling into the next page and from writing unfilled lanes. A sweep over each lock index, with a commit aimed at each quarter, shows that only the matching quarter is blocked. Commands issued during a busy window, followed by targeted commits and reads, show that none of them changed the bank, the locks or the buffer.

// File: rtl/spd_pw_pkg.sv
package spd_pw_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_ADDR   = 3'd1,
    OP_DATA   = 3'd2,
    OP_COMMIT = 3'd3,
    OP_BANK   = 3'd4,
    OP_PSET   = 3'd5,
    OP_PCLR   = 3'd6,
    OP_READ   = 3'd7
  } spd_op_e;
endpackage

// File: rtl/spd_pw_pagebuf.sv
module spd_pw_pagebuf #(
  parameter int PAGE_BYTES = 16,
  parameter int ROWW       = 5,
  localparam int OFFW      = $clog2(PAGE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [ROWW-1:0]         load_row,
  input  logic [OFFW-1:0]         load_off,
  input  logic                    put,
  input  logic [7:0]              put_byte,
  input  logic                    clear,
  output logic [ROWW-1:0]         row,
  output logic [PAGE_BYTES-1:0]   mask,
  output logic [PAGE_BYTES*8-1:0] bytes
);
  logic [OFFW-1:0] slot_q;

  // slot advance stays inside the page
  function automatic logic [OFFW-1:0] next_slot(input logic [OFFW-1:0] s);
    return s + OFFW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row    <= '0;
      mask   <= '0;
      slot_q <= '0;
    end else if (load) begin
      row    <= load_row;
      mask   <= '0;
      slot_q <= load_off;
    end else if (clear) begin
      mask <= '0;
    end else if (put) begin
      mask[slot_q] <= 1'b1;
      slot_q       <= next_slot(slot_q);
    end
  end

  always_ff @(posedge clk) begin
    if (put && !load) bytes[slot_q*8 +: 8] <= put_byte;
  end
endmodule

// File: rtl/spd_pw_protect.sv
module spd_pw_protect #(
  parameter int NUM_BLOCKS = 4,
  localparam int BLKW      = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  set_en,
  input  logic [BLKW-1:0]       set_idx,
  input  logic                  clr_en,
  output logic [NUM_BLOCKS-1:0] flags
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr_en) flags <= '0;
    else if (set_en)      flags[set_idx] <= 1'b1;
  end
endmodule

// File: rtl/spd_pw_array.sv
module spd_pw_array #(
  parameter int PAGE_BYTES = 16,
  parameter int ROWW       = 5,
  localparam int OFFW      = $clog2(PAGE_BYTES),
  localparam int AW        = ROWW + OFFW,
  localparam int DEPTH     = 2**AW
) (
  input  logic                    clk,
  input  logic [PAGE_BYTES-1:0]   we,
  input  logic [ROWW-1:0]         wrow,
  input  logic [PAGE_BYTES*8-1:0] wbytes,
  input  logic                    re,
  input  logic [AW-1:0]           raddr,
  output logic [7:0]              rdata
);
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (we[i]) store[{wrow, OFFW'(i)}] <= wbytes[i*8 +: 8];
    end
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/spd_pw_top.sv
module spd_pw_top #(
  parameter int BANK_BYTES = 256,
  parameter int NUM_BANKS  = 2,
  parameter int PAGE_BYTES = 16,
  parameter int NUM_BLOCKS = 4,
  parameter int WR_CYCLES  = 1000,
  localparam int AW   = $clog2(BANK_BYTES),
  localparam int BW   = $clog2(NUM_BANKS),
  localparam int OFFW = $clog2(PAGE_BYTES),
  localparam int ROWW = BW + AW - OFFW,
  localparam int BLKW = $clog2(NUM_BLOCKS),
  localparam int CNTW = $clog2(WR_CYCLES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [2:0]            cmd_op,
  input  logic [AW-1:0]         cmd_addr,
  input  logic [7:0]            cmd_data,
  output logic                  busy,
  output logic [PAGE_BYTES-1:0] mem_we,
  output logic [ROWW-1:0]       mem_row,
  output logic [7:0]            rd_data,
  output logic                  rd_valid
);
  import spd_pw_pkg::*;

  function automatic logic [BLKW-1:0] block_of(input logic [ROWW-1:0] r);
    return r[ROWW-1 -: BLKW];
  endfunction

  spd_op_e                 op;
  logic                    accept;
  logic                    addr_fire, data_fire, commit_req, bank_fire;
  logic                    pset_fire, clr_fire, read_fire;
  logic                    start_fire, discard_fire, write_fire, drop_buf;
  logic                    blk_locked, has_bytes;
  logic [BW-1:0]           bank_q;
  logic                    busy_q;
  logic [CNTW-1:0]         cnt_q;
  logic [ROWW-1:0]         buf_row;
  logic [PAGE_BYTES-1:0]   buf_mask;
  logic [PAGE_BYTES*8-1:0] buf_bytes;
  logic [NUM_BLOCKS-1:0]   prot_flags;

  assign op         = spd_op_e'(cmd_op);
  assign accept     = cmd_valid && !busy_q;
  assign addr_fire  = accept && (op == OP_ADDR);
  assign data_fire  = accept && (op == OP_DATA);
  assign commit_req = accept && (op == OP_COMMIT);
  assign bank_fire  = accept && (op == OP_BANK);
  assign pset_fire  = accept && (op == OP_PSET);
  assign clr_fire   = accept && (op == OP_PCLR);
  assign read_fire  = accept && (op == OP_READ);

  assign has_bytes    = |buf_mask;
  assign blk_locked   = prot_flags[block_of(buf_row)];
  assign start_fire   = commit_req && has_bytes && !blk_locked;
  assign discard_fire = commit_req && has_bytes && blk_locked;
  assign write_fire   = busy_q && (cnt_q == '0);
  assign drop_buf     = write_fire || discard_fire;

  always_ff @(posedge clk) begin
    if (!rst_n)         bank_q <= '0;
    else if (bank_fire) bank_q <= cmd_data[BW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_fire) begin
      busy_q <= 1'b1;
      cnt_q  <= CNTW'(WR_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CNTW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= read_fire;
  end

  spd_pw_pagebuf #(.PAGE_BYTES(PAGE_BYTES), .ROWW(ROWW)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (addr_fire),
    .load_row ({bank_q, cmd_addr[AW-1:OFFW]}),
    .load_off (cmd_addr[OFFW-1:0]),
    .put      (data_fire),
    .put_byte (cmd_data),
    .clear    (drop_buf),
    .row      (buf_row),
    .mask     (buf_mask),
    .bytes    (buf_bytes)
  );

  spd_pw_protect #(.NUM_BLOCKS(NUM_BLOCKS)) u_prot (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (pset_fire),
    .set_idx (cmd_data[BLKW-1:0]),
    .clr_en  (clr_fire),
    .flags   (prot_flags)
  );

  assign busy    = busy_q;
  assign mem_we  = write_fire ? buf_mask : '0;
  assign mem_row = buf_row;

  spd_pw_array #(.PAGE_BYTES(PAGE_BYTES), .ROWW(ROWW)) u_arr (
    .clk    (clk),
    .we     (mem_we),
    .wrow   (buf_row),
    .wbytes (buf_bytes),
    .re     (read_fire),
    .raddr  ({bank_q, cmd_addr}),
    .rdata  (rd_data)
  );
endmodule

// File: rtl/spd_pw_checker.sv
module spd_pw_checker #(
  parameter int WR_CYCLES  = 1000,
  parameter int PAGE_BYTES = 16,
  parameter int ROWW       = 5,
  parameter int NUM_BLOCKS = 4,
  parameter int BW         = 1,
  localparam int BLKW      = $clog2(NUM_BLOCKS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic [2:0]            cmd_op,
  input logic                  busy,
  input logic [PAGE_BYTES-1:0] mem_we,
  input logic [ROWW-1:0]       mem_row,
  input logic                  rd_valid,
  input logic [BW-1:0]         bank_q,
  input logic [NUM_BLOCKS-1:0] prot_flags,
  input logic                  clr_fire
);
  int run_len;
  logic [BLKW-1:0] row_blk;
  logic            row_locked;

  assign row_blk    = mem_row[ROWW-1 -: BLKW];
  assign row_locked = prot_flags[row_blk];

  always_ff @(posedge clk) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  // R5: busy window length, counted instead of unrolled
  assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == WR_CYCLES));

  // R5: strobes only in the last busy cycle
  assert_we_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_we) |-> busy ##1 !busy);

  // R8: never a strobe into a locked quarter
  assert_no_we_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_we) |-> !row_locked);

  // R6: bank and locks frozen while busy
  assert_bank_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(bank_q));
  assert_lock_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(prot_flags));

  // R6: no read response to a command issued while busy
  assert_no_read_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rd_valid);

  // R2: accepted read answers next cycle
  assert_read_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd7 && !busy) |=> rd_valid);

  // R9: a lock only drops after a clear command
  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_fire |=> (($past(prot_flags) & ~prot_flags) == '0));
endmodule

bind spd_pw_top spd_pw_checker #(
  .WR_CYCLES(WR_CYCLES), .PAGE_BYTES(PAGE_BYTES), .ROWW(ROWW),
  .NUM_BLOCKS(NUM_BLOCKS), .BW(BW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .busy(busy), .mem_we(mem_we), .mem_row(mem_row), .rd_valid(rd_valid),
  .bank_q(bank_q), .prot_flags(prot_flags), .clr_fire(clr_fire)
);

// File: tb/spd_pw_top_test.sv
module spd_pw_top_test;
  import spd_pw_pkg::*;
  localparam int WR = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [7:0]  cmd_addr = '0;
  logic [7:0]  cmd_data = '0;
  logic        busy;
  logic [15:0] mem_we;
  logic [4:0]  mem_row;
  logic [7:0]  rd_data;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0]  refm [512];
  logic [7:0]  mbuf [16];
  logic [15:0] mmask = '0;
  logic [3:0]  mslot = '0;
  logic [4:0]  mrow = '0;
  logic        mbank = 1'b0;
  logic [3:0]  mprot = '0;

  spd_pw_top #(.WR_CYCLES(WR)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy), .mem_we(mem_we),
    .mem_row(mem_row), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic raw(input spd_op_e op, input logic [7:0] a, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'(OP_NOP);
  endtask

  function automatic logic [7:0] pat(input int b, input int p, input int i);
    return 8'((b * 16 + p) * 7 + i * 13 + 1);
  endfunction

  task automatic m_addr(input logic [7:0] a);
    raw(OP_ADDR, a, 8'h00);
    mrow = {mbank, a[7:4]}; mslot = a[3:0]; mmask = '0;
  endtask

  task automatic m_data(input logic [7:0] d);
    raw(OP_DATA, 8'h00, d);
    mbuf[mslot] = d; mmask[mslot] = 1'b1; mslot = mslot + 4'd1;
  endtask

  task automatic m_bank(input logic b);
    raw(OP_BANK, 8'h00, {7'd0, b});
    mbank = b;
  endtask

  task automatic m_pset(input logic [1:0] k);
    raw(OP_PSET, 8'h00, {6'd0, k});
    mprot[k] = 1'b1;
  endtask

  task automatic m_pclr();
    raw(OP_PCLR, 8'h00, 8'h00);
    mprot = '0;
  endtask

  task automatic apply_commit();
    for (int i = 0; i < 16; i++)
      if (mmask[i]) refm[{mrow, 4'(i)}] = mbuf[i];
    mmask = '0;
  endtask

  // commit and follow the busy window; go = write expected
  task automatic do_commit(input string req);
    logic go;
    int n;
    go = (mmask != 0) && !mprot[mrow[4:3]];
    raw(OP_COMMIT, 8'h00, 8'h00);
    if (!go) begin
      check({req, " no busy"}, busy, 1'b0);
      check({req, " no strobe"}, mem_we, 16'h0);
      mmask = '0;
    end else begin
      n = 0;
      while (busy && n < 200) begin
        n++;
        if (mem_we != 0) begin
          check("R5 strobe cycle", n, WR);
          check({req, " strobe mask"}, mem_we, mmask);
          check({req, " row"}, mem_row, mrow);
        end
        @(negedge clk);
      end
      check("R5 busy length", n, WR);
      apply_commit();
    end
  endtask

  task automatic rd(input string req, input logic [7:0] a);
    raw(OP_READ, a, 8'h00);
    check({req, " rd_valid"}, rd_valid, 1'b1);
    check({req, " rd_data"}, rd_data, refm[{mbank, a}]);
  endtask

  task automatic rd_page(input string req, input logic [3:0] p);
    for (int i = 0; i < 16; i++) rd(req, {p, 4'(i)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 1'b0);
    check("R1 rd_valid", rd_valid, 1'b0);
    check("R1 mem_we", mem_we, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R5 R7: fill every page of both banks
    for (int b = 0; b < 2; b++) begin
      m_bank(b[0]);
      for (int p = 0; p < 16; p++) begin
        m_addr({p[3:0], 4'h0});
        for (int i = 0; i < 16; i++) m_data(pat(b, p, i));
        do_commit("R4 full page");
      end
    end
    // R2 R7: read back all bytes of both banks
    for (int b = 0; b < 2; b++) begin
      m_bank(b[0]);
      for (int a = 0; a < 256; a++) rd("R2 R7 readback", a[7:0]);
    end

    // R3: 20 bytes from slot 14 wrap inside the page
    m_bank(1'b0);
    m_addr(8'h3E);
    for (int i = 0; i < 20; i++) m_data(8'hA0 + 8'(i));
    do_commit("R3 wrap");
    rd_page("R3 wrap page", 4'h3);
    rd_page("R3 next page untouched", 4'h4);

    // R4: partial run of 3 bytes mid-page in bank 1
    m_bank(1'b1);
    m_addr(8'h54);
    for (int i = 0; i < 3; i++) m_data(8'h5A ^ 8'(i));
    do_commit("R4 partial");
    rd_page("R4 partial page", 4'h5);

    // R10: empty commit
    m_addr(8'h60);
    do_commit("R10 empty");

    // R8: lock sweep, quarter = {bank, addr bit 7}
    for (int k = 0; k < 4; k++) begin
      m_pset(k[1:0]);
      for (int j = 0; j < 4; j++) begin
        m_bank(j[1]);
        m_addr({j[0], 3'd1, 4'd2});
        m_data(8'(k * 16 + j + 3));
        do_commit("R8 lock sweep");
        rd("R8 lock sweep read", {j[0], 3'd1, 4'd2});
      end
      m_pclr();
    end
    // R8: discarded buffer is empty afterwards
    m_pset(2'd0);
    m_bank(1'b0);
    m_addr(8'h07);
    m_data(8'hEE);
    do_commit("R8 locked");
    m_pclr();
    do_commit("R8 buffer emptied");
    rd("R8 unchanged", 8'h07);

    // R9: lock survives other commands
    m_pset(2'd2);
    m_bank(1'b0);
    m_addr(8'h91);
    m_data(8'h33);
    do_commit("R9 other quarter");
    m_bank(1'b1);
    rd("R9 read", 8'h10);
    m_addr(8'h22);
    m_data(8'h44);
    do_commit("R9 still locked");
    rd("R9 unchanged", 8'h22);
    m_pclr();
    m_addr(8'h22);
    m_data(8'h45);
    do_commit("R9 after clear");
    rd("R9 written", 8'h22);

    // R6: commands while busy are ignored
    m_bank(1'b0);
    m_addr(8'h20);
    m_data(8'h71);
    m_data(8'h72);
    raw(OP_COMMIT, 8'h00, 8'h00);
    check("R6 busy started", busy, 1'b1);
    raw(OP_BANK, 8'h00, 8'h01);
    raw(OP_PSET, 8'h00, 8'h00);
    raw(OP_ADDR, 8'hF0, 8'h00);
    raw(OP_DATA, 8'h00, 8'h99);
    raw(OP_READ, 8'h00, 8'h00);
    check("R6 no read response", rd_valid, 1'b0);
    while (busy) @(negedge clk);
    apply_commit();
    rd_page("R6 bank and row kept", 4'h2);
    do_commit("R6 buffer empty");
    m_addr(8'h01);
    m_data(8'h61);
    do_commit("R6 lock not set");
    rd("R6 lock not set read", 8'h01);

    // R1: reset returns to bank 0, storage kept
    m_bank(1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    mbank = 1'b0; mmask = '0; mprot = '0;
    @(negedge clk);
    rd("R1 bank 0 after reset", 8'h35);
    rd("R1 bank 0 after reset", 8'hC4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule